// File: doc/BRIEF.md
# DMA Status and Interrupt Combiner

This block holds the control and status registers of a SCSI host adapter's DMA engine. It combines the adapter's two interrupt causes into one level-sensitive host interrupt line. The first cause is the SCSI protocol core, whose interrupt level is mirrored into a status flag. The second cause is the DMA datapath's transfer-complete event. That event sets a done flag, and the done flag reaches the host line only when the done-interrupt enable in the command register is set. The SCSI flag always reaches the line, whatever the enable holds.

Host software uses a simple synchronous register port inside a 0x80-byte window. It reads status and writes ones to clear the error, abort and done flags. When the status-mode bit in the bus-interface control register is zero, a status read also clears those flags. The DMA datapath drives single-cycle strobes for completion, error and abort. A completion strobe also zeroes the working byte count register.

Top module: `dma_irq_regs`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero and `irq_out` is low.
- R2: `irq_out` is high exactly when the SCSI flag (status bit 4) is set, or when the done flag (status bit 3) and the done-interrupt enable (command bit 7) are both set.
- R3: The SCSI flag takes the level of `scsi_irq_in` at each clock edge. It is set while the input is high and clear after the input falls.
- R4: A write to the status word (byte offset 0x14) clears the error (bit 0), abort (bit 1) and done (bit 3) flags wherever the written data holds a one. The write leaves every other flag, including the SCSI flag, as it was.
- R5: Reads have one cycle of latency. `reg_rdata` shows the addressed register's value from before the read's own side effects, one clock edge after the read is presented.
- R6: A status read clears error, abort and done only when bus-control bit 24 (status mode) is zero. When that bit is one, a status read leaves the flags as they were.
- R7: A `xfer_done` strobe sets the done flag and zeroes the working byte count (byte offset 0x10).
- R8: Setting the done flag while command bit 7 is clear leaves `irq_out` low. Setting bit 7 later raises the line.
- R9: When a set strobe and a clearing access (a write-one or a read-to-clear) reach the same flag in the same cycle, the flag ends set.
- R10: The command word (0x00), byte count (0x10) and bus-control word (0x30) are fully writable and read back. Other offsets and accesses with non-zero low address bits read zero and change nothing.
- R11: The `xfer_err` and `xfer_abort` strobes set the error and abort flags. Neither one affects `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Byte address within the 0x80 window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after `reg_rd` |
| scsi_irq_in | input | 1 | Interrupt level from the SCSI core |
| xfer_done | input | 1 | Transfer-complete strobe from the DMA datapath |
| xfer_err | input | 1 | Transfer-error strobe |
| xfer_abort | input | 1 | Transfer-abort strobe |
| irq_out | output | 1 | Combined level-sensitive host interrupt |

## Verification
The interrupt combiner is tried with four source patterns: the SCSI level alone, the done flag with its enable off, the done flag with its enable on, and both sources together. Together these show whether the enable gates only the done path. The flag-clearing logic is tried with write-one masks that select single bits, with reads under each status mode, and with a completion strobe that lands in the same cycle as a clear. These patterns reveal a wrong clear mask, a missing mode check, and a lost completion. Byte count writes followed by a completion confirm that the strobe zeroes the count.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    // byte offsets inside the register window
    localparam int unsigned OFS_CMD  = 32'h00;
    localparam int unsigned OFS_WBC  = 32'h10;
    localparam int unsigned OFS_STAT = 32'h14;
    localparam int unsigned OFS_BIU  = 32'h30;

    // bit positions
    localparam int unsigned ST_ERR     = 0;
    localparam int unsigned ST_ABT     = 1;
    localparam int unsigned ST_DONE    = 3;
    localparam int unsigned ST_SCSI    = 4;
    localparam int unsigned CMD_DIE    = 7;
    localparam int unsigned BIU_STMODE = 24;

    typedef struct packed {
        logic scsi;
        logic done;
        logic abrt;
        logic err;
    } stat_t;
endpackage

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
    import dma_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  scsi_lvl,
    input  logic  set_err,
    input  logic  set_abt,
    input  logic  set_done,
    input  logic  clr_err,
    input  logic  clr_abt,
    input  logic  clr_done,
    output stat_t stat_o
);
    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.scsi = scsi_lvl;
        // clears first so that a simultaneous set overrides them
        if (clr_err)  st_d.err  = 1'b0;
        if (clr_abt)  st_d.abrt = 1'b0;
        if (clr_done) st_d.done = 1'b0;
        if (set_err)  st_d.err  = 1'b1;
        if (set_abt)  st_d.abrt = 1'b1;
        if (set_done) st_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q;

    // R3
    scsi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.scsi == $past(scsi_lvl)));
    // R9
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> st_q.done);
    // R11
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_err && set_abt) |=> (st_q.err && st_q.abrt));
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_wbc,
    input  logic              wr_biu,
    input  logic [DATA_W-1:0] wdata,
    input  logic              zero_wbc,
    output logic [DATA_W-1:0] cmd_o,
    output logic [DATA_W-1:0] wbc_o,
    output logic [DATA_W-1:0] biu_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] wbc;
        logic [DATA_W-1:0] biu;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_cmd)   cfg_d.cmd = wdata;
        if (wr_biu)   cfg_d.biu = wdata;
        if (wr_wbc)   cfg_d.wbc = wdata;
        if (zero_wbc) cfg_d.wbc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cmd_o = cfg_q.cmd;
    assign wbc_o = cfg_q.wbc;
    assign biu_o = cfg_q.biu;

    // R7
    wbc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wbc |=> (cfg_q.wbc == '0));
    // R10
    cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> (cfg_q.cmd == $past(wdata)));
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge (
    input  logic scsi_flag,
    input  logic done_flag,
    input  logic done_en,
    output logic irq
);
    logic dma_lvl;

    always_comb begin
        dma_lvl = done_flag & done_en;
        irq     = scsi_flag | dma_lvl;
    end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              scsi_irq_in,
    input  logic              xfer_done,
    input  logic              xfer_err,
    input  logic              xfer_abort,
    output logic              irq_out
);
    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_CMD  = WORD_W'(OFS_CMD  >> 2);
    localparam logic [WORD_W-1:0] W_WBC  = WORD_W'(OFS_WBC  >> 2);
    localparam logic [WORD_W-1:0] W_STAT = WORD_W'(OFS_STAT >> 2);
    localparam logic [WORD_W-1:0] W_BIU  = WORD_W'(OFS_BIU  >> 2);

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              hit_cmd, hit_wbc, hit_stat, hit_biu;
    logic              rd_clr, stmode;
    logic [DATA_W-1:0] cmd_q, wbc_q, biu_q, stat_word;
    stat_t             stat;

    always_comb begin
        word     = reg_addr[ADDR_W-1:2];
        aligned  = (reg_addr[1:0] == 2'b00);
        hit_cmd  = aligned && (word == W_CMD);
        hit_wbc  = aligned && (word == W_WBC);
        hit_stat = aligned && (word == W_STAT);
        hit_biu  = aligned && (word == W_BIU);
        stmode   = biu_q[BIU_STMODE];
        rd_clr   = reg_rd && hit_stat && !stmode;
    end

    dma_stat_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .scsi_lvl (scsi_irq_in),
        .set_err  (xfer_err),
        .set_abt  (xfer_abort),
        .set_done (xfer_done),
        .clr_err  (rd_clr || (reg_wr && hit_stat && reg_wdata[ST_ERR])),
        .clr_abt  (rd_clr || (reg_wr && hit_stat && reg_wdata[ST_ABT])),
        .clr_done (rd_clr || (reg_wr && hit_stat && reg_wdata[ST_DONE])),
        .stat_o   (stat)
    );

    dma_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd   (reg_wr && hit_cmd),
        .wr_wbc   (reg_wr && hit_wbc),
        .wr_biu   (reg_wr && hit_biu),
        .wdata    (reg_wdata),
        .zero_wbc (xfer_done),
        .cmd_o    (cmd_q),
        .wbc_o    (wbc_q),
        .biu_o    (biu_q)
    );

    dma_irq_merge u_merge (
        .scsi_flag (stat.scsi),
        .done_flag (stat.done),
        .done_en   (cmd_q[CMD_DIE]),
        .irq       (irq_out)
    );

    always_comb begin
        stat_word          = '0;
        stat_word[ST_ERR]  = stat.err;
        stat_word[ST_ABT]  = stat.abrt;
        stat_word[ST_DONE] = stat.done;
        stat_word[ST_SCSI] = stat.scsi;
    end

    // read path
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (reg_rd) begin
            rdata_d = '0;
            if (hit_cmd)  rdata_d = cmd_q;
            if (hit_wbc)  rdata_d = wbc_q;
            if (hit_stat) rdata_d = stat_word;
            if (hit_biu)  rdata_d = biu_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign reg_rdata = rdata_q;

    // R1
    always_comb begin
        if (!rst_n) begin
            irq_rst_chk: assert (!irq_out);
        end
    end
    // R8
    gate_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_q[CMD_DIE] && !stat.scsi) |-> !irq_out);
    // R2
    scsi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat.scsi |-> irq_out);
    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !xfer_done && !xfer_err && !xfer_abort)
        |=> (!stat.done && !stat.err && !stat.abrt));
    // R4
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_stat && !reg_wdata[ST_DONE] && !rd_clr)
        |=> (stat.done || !$past(stat.done)));
    // R5
    rd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_cmd) |=> (reg_rdata == $past(cmd_q)));
endmodule

// File: tb/dma_irq_regs_test.sv
module dma_irq_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scsi_irq_in = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_err = 1'b0;
    logic        xfer_abort = 1'b0;
    logic        irq_out;

    int nchk = 0;
    int nbad = 0;

    localparam logic [6:0] A_CMD  = 7'h00;
    localparam logic [6:0] A_WBC  = 7'h10;
    localparam logic [6:0] A_STAT = 7'h14;
    localparam logic [6:0] A_BIU  = 7'h30;

    always #2 clk = ~clk;

    dma_irq_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scsi_irq_in(scsi_irq_in), .xfer_done(xfer_done), .xfer_err(xfer_err),
        .xfer_abort(xfer_abort), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input bit dn, input bit er, input bit ab);
        @(negedge clk);
        xfer_done = dn; xfer_err = er; xfer_abort = ab;
        @(negedge clk);
        xfer_done = 1'b0; xfer_err = 1'b0; xfer_abort = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq in reset", {31'b0, irq_out}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(A_CMD, v);  check("R1 cmd", v, 32'h0);
        rd(A_WBC, v);  check("R1 wbc", v, 32'h0);
        rd(A_STAT, v); check("R1 stat", v, 32'h0);
        rd(A_BIU, v);  check("R1 biu", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_CMD, 32'h0000_0040); rd(A_CMD, v); check("R10 cmd readback", v, 32'h0000_0040);
        wr(A_WBC, 32'h0001_2345); rd(A_WBC, v); check("R10 wbc readback", v, 32'h0001_2345);
        wr(A_BIU, 32'h0100_0000); rd(A_BIU, v); check("R10 biu readback", v, 32'h0100_0000);
        wr(7'h20, 32'hFFFF_FFFF); rd(7'h20, v); check("R10 unmapped", v, 32'h0);
        wr(7'h01, 32'hFFFF_FFFF); rd(A_CMD, v); check("R10 misaligned write", v, 32'h0000_0040);
        rd(7'h11, v); check("R10 misaligned read", v, 32'h0);
        // R5: value is visible one edge after the read strobe
        @(negedge clk); reg_rd = 1'b1; reg_addr = A_WBC;
        @(negedge clk); reg_rd = 1'b0;
        check("R5 latency", reg_rdata, 32'h0001_2345);
        wr(A_CMD, 32'h0); wr(A_BIU, 32'h0);
    endtask

    task automatic t_scsi();
        logic [31:0] v;
        @(negedge clk); scsi_irq_in = 1'b1;
        @(negedge clk);
        check("R3 irq from scsi", {31'b0, irq_out}, 32'h1);
        rd(A_STAT, v); check("R3 scsi flag", v, 32'h10);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R4 scsi survives w1c", v, 32'h10);
        @(negedge clk); scsi_irq_in = 1'b0;
        @(negedge clk);
        check("R3 irq drops", {31'b0, irq_out}, 32'h0);
        rd(A_STAT, v); check("R3 scsi clear", v, 32'h0);
    endtask

    task automatic t_done_gate();
        logic [31:0] v;
        wr(A_BIU, 32'h0100_0000);
        pulse(1'b1, 1'b0, 1'b0);
        check("R8 no irq without enable", {31'b0, irq_out}, 32'h0);
        rd(A_STAT, v); check("R8 done set", v, 32'h08);
        wr(A_CMD, 32'h80);
        check("R8 enable raises irq", {31'b0, irq_out}, 32'h1);
        @(negedge clk); scsi_irq_in = 1'b1;
        @(negedge clk);
        wr(A_STAT, 32'h08);
        check("R2 scsi holds irq", {31'b0, irq_out}, 32'h1);
        @(negedge clk); scsi_irq_in = 1'b0;
        @(negedge clk);
        check("R2 irq low after both clear", {31'b0, irq_out}, 32'h0);
        pulse(1'b0, 1'b1, 1'b1);
        check("R11 err/abort no irq", {31'b0, irq_out}, 32'h0);
        wr(A_STAT, 32'h03);
        wr(A_CMD, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(1'b1, 1'b1, 1'b1);
        rd(A_STAT, v); check("R11 flags set", v, 32'h0B);
        wr(A_STAT, 32'h02);
        rd(A_STAT, v); check("R4 clear abort only", v, 32'h09);
        wr(A_STAT, 32'h08);
        rd(A_STAT, v); check("R4 clear done only", v, 32'h01);
        wr(A_STAT, 32'h01);
        rd(A_STAT, v); check("R4 clear err", v, 32'h00);
    endtask

    task automatic t_rdclr();
        logic [31:0] v;
        pulse(1'b1, 1'b1, 1'b0);
        rd(A_STAT, v); check("R6 mode1 first read", v, 32'h09);
        rd(A_STAT, v); check("R6 mode1 no clear", v, 32'h09);
        wr(A_BIU, 32'h0);
        rd(A_STAT, v); check("R6 mode0 read value", v, 32'h09);
        rd(A_STAT, v); check("R6 mode0 cleared", v, 32'h00);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(A_WBC, 32'h0000_0055);
        pulse(1'b1, 1'b0, 1'b0);
        rd(A_WBC, v); check("R7 count zeroed", v, 32'h0);
        rd(A_STAT, v); check("R7 done set", v, 32'h08);
    endtask

    task automatic t_race();
        logic [31:0] v;
        // mode 0: read-to-clear coincides with completion
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_STAT; xfer_done = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; xfer_done = 1'b0;
        check("R9 read shows old", reg_rdata, 32'h0);
        rd(A_STAT, v); check("R9 done kept over read clear", v, 32'h08);
        // write-one-clear coincides with completion
        wr(A_BIU, 32'h0100_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h08; xfer_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; xfer_done = 1'b0;
        rd(A_STAT, v); check("R9 done kept over w1c", v, 32'h08);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                t_regs();
                t_scsi();
                t_done_gate();
                t_w1c();
                t_rdclr();
                t_count();
                t_race();
            end
            begin
                repeat (100000) @(posedge clk);
                nbad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule